// File: doc/BRIEF.md
# Trace Payload Byte Formatter

This block turns debug trace events from a processor core into a stream of payload bytes on a narrow trace data port. It handles two kinds of event. A taken branch carries a 32-bit target address. An ownership event carries the 8-bit address-space identifier (ASID). Three core conditions raise an ownership event: entry into user mode, an instruction that loads the ASID control register, and a debug command that synchronises the PC. A 2-bit target-size setting picks how many low-order address bytes a branch contributes. An enable bit turns ownership records on or off.

Each accepted event becomes one record of zero to five bytes. The whole record is written in one cycle into a byte FIFO, which is 8 entries deep by default. The FIFO drains one byte per cycle onto the trace port. When the FIFO does not have room for the whole record that is being offered, the block raises a stall. The event source must then hold the event until the stall clears, so no record is ever dropped. The configuration is sampled only in the cycle a record is accepted, so a setting change never splits a record.

Top module: `trace_payload_fmt`

## Requirements
- R1: A synchronous active-high reset empties the FIFO and discards any queued bytes. After the reset edge, td_valid is low and ev_stall is low.
- R2: With target-size setting 2'b00, a taken branch contributes no address bytes.
- R3: With target-size setting 2'b01, a taken branch contributes target bits [7:0] and then bits [15:8].
- R4: With target-size setting 2'b10, a taken branch contributes target bytes 0, 1 and 2, in that order (least significant first).
- R5: With target-size setting 2'b11, a taken branch contributes all four target bytes, least significant first.
- R6: While the ownership enable is low, no ASID byte is ever emitted, whichever triggers are raised.
- R7: While the ownership enable is high, user-mode entry, an ASID register load or a PC-sync command each produce exactly one ASID byte. Several of these triggers in the same cycle still produce a single byte.
- R8: When a branch and an ownership trigger arrive in the same cycle, they form one record: the address bytes come first and the ASID byte comes last.
- R9: Queued bytes leave in order, one per cycle, with td_valid high on every cycle in which a byte is presented. td_valid stays high until the FIFO is empty.
- R10: ev_stall is high exactly when the offered record is longer than the free FIFO entries. A record that is held through a stall is later emitted once and complete.
- R11: The target-size and ownership settings are applied in the cycle a record is accepted. Changing them afterwards does not alter bytes that are already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tgt_sel | input | 2 | Branch target byte count select |
| cfg_own_en | input | 1 | Ownership (ASID) trace enable |
| br_valid | input | 1 | Taken-branch event |
| br_target | input | 32 | Branch target address |
| own_user_entry | input | 1 | Ownership trigger: entry into user mode |
| own_asid_load | input | 1 | Ownership trigger: ASID register load |
| own_pc_sync | input | 1 | Ownership trigger: debug PC-sync command |
| own_asid | input | 8 | Current ASID value |
| ev_stall | output | 1 | Offered record does not fit; hold the event |
| td_valid | output | 1 | Trace byte valid |
| td_byte | output | 8 | Trace payload byte |

## Verification
The bench uses the default depth of 8 entries. The longest record is five bytes, so one maximal record followed by a second one already overruns the free space. This makes the stall path, and its release as bytes drain, easy to reach in both directed and random traffic. It also lets records wrap around the pointer boundary many times. Random events are held while stalled, as a real source would hold them, and the byte stream is compared against a queue model. Directed cases cover each target size, the ownership triggers alone and together, a configuration change right after acceptance, and a reset while the FIFO holds data.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    localparam int ADDR_BYTES = 4;
    localparam int REC_MAX    = ADDR_BYTES + 1;
    localparam int LEN_W      = $clog2(REC_MAX + 1);

    typedef enum logic [1:0] {
        TSEL_NONE = 2'b00,
        TSEL_LO2  = 2'b01,
        TSEL_LO3  = 2'b10,
        TSEL_ALL  = 2'b11
    } tgt_sel_e;

    typedef struct packed {
        tgt_sel_e tgt_sel;
        logic     own_en;
    } tpf_cfg_t;

    typedef struct packed {
        logic       user_entry;
        logic       asid_load;
        logic       pc_sync;
    } own_trig_t;

    typedef struct packed {
        logic [REC_MAX-1:0][7:0] data;
        logic [LEN_W-1:0]        len;
    } tpf_rec_t;

    function automatic logic [LEN_W-1:0] addr_len(tgt_sel_e sel);
        case (sel)
            TSEL_NONE: addr_len = LEN_W'(0);
            TSEL_LO2:  addr_len = LEN_W'(2);
            TSEL_LO3:  addr_len = LEN_W'(3);
            default:   addr_len = LEN_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/tpf_rec_build.sv
module tpf_rec_build
    import tpf_pkg::*;
(
    input  tpf_cfg_t     cfg,
    input  logic         br_valid,
    input  logic [31:0]  br_target,
    input  own_trig_t    trig,
    input  logic [7:0]   asid,
    output tpf_rec_t     rec
);

    logic [LEN_W-1:0] alen;
    logic             own_hit;

    always_comb begin
        alen    = br_valid ? addr_len(cfg.tgt_sel) : LEN_W'(0);
        own_hit = cfg.own_en && (trig.user_entry || trig.asid_load || trig.pc_sync);
        rec.len = alen + LEN_W'(own_hit);
        for (int i = 0; i < REC_MAX; i++) begin
            if (i < int'(alen)) begin
                rec.data[i] = br_target[8*(i % ADDR_BYTES) +: 8];
            end else if (i == int'(alen)) begin
                rec.data[i] = asid;
            end else begin
                rec.data[i] = 8'h00;
            end
        end
    end

endmodule

// File: rtl/tpf_byte_fifo.sv
module tpf_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int MAXW  = 5,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = $clog2(MAXW + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [LW-1:0]         wr_len,
    input  logic [MAXW-1:0][7:0]  wr_data,
    input  logic                  pop,
    output logic [7:0]            rd_data,
    output logic [CW-1:0]         count
);

    logic [PW-1:0]          wr_ptr;
    logic [PW-1:0]          rd_ptr;
    logic [7:0]             mem [DEPTH];
    logic [DEPTH-1:0][7:0]  pad;

    initial begin
        assert ((1 << PW) == DEPTH && DEPTH >= MAXW)
            else $error("tpf_byte_fifo: DEPTH must be a power of two not below MAXW");
    end

    always_comb begin
        pad = '0;
        for (int i = 0; i < MAXW; i++) begin
            pad[i] = wr_data[i];
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [PW-1:0] off;
        assign off = PW'(s) - wr_ptr;
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[s] <= 8'h00;
            end else if (wr_en && (int'(off) < int'(wr_len))) begin
                mem[s] <= pad[off];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + PW'(wr_len);
            if (pop)   rd_ptr <= rd_ptr + PW'(1);
            count <= count + (wr_en ? CW'(wr_len) : CW'(0)) - (pop ? CW'(1) : CW'(0));
        end
    end

    assign rd_data = mem[rd_ptr];

    // R10: occupancy never exceeds the storage
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R9: a pop is only requested when a byte is held
    a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);

    // R9: with no write, a nonempty FIFO drains by exactly one byte
    a_r9_single_drain: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && count != '0) |=> count == $past(count) - CW'(1));

endmodule

// File: rtl/trace_payload_fmt.sv
module trace_payload_fmt
    import tpf_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_tgt_sel,
    input  logic        cfg_own_en,
    input  logic        br_valid,
    input  logic [31:0] br_target,
    input  logic        own_user_entry,
    input  logic        own_asid_load,
    input  logic        own_pc_sync,
    input  logic [7:0]  own_asid,
    output logic        ev_stall,
    output logic        td_valid,
    output logic [7:0]  td_byte
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);

    tpf_cfg_t        cfg;
    own_trig_t       trig;
    tpf_rec_t        rec;
    logic [CW-1:0]   count;
    logic [CW-1:0]   room;
    logic            wr_en;
    logic            pop;

    assign cfg.tgt_sel      = tgt_sel_e'(cfg_tgt_sel);
    assign cfg.own_en       = cfg_own_en;
    assign trig.user_entry  = own_user_entry;
    assign trig.asid_load   = own_asid_load;
    assign trig.pc_sync     = own_pc_sync;

    tpf_rec_build u_build (
        .cfg       (cfg),
        .br_valid  (br_valid),
        .br_target (br_target),
        .trig      (trig),
        .asid      (own_asid),
        .rec       (rec)
    );

    assign room     = CW'(FIFO_DEPTH) - count;
    assign ev_stall = int'(rec.len) > int'(room);
    assign wr_en    = (rec.len != '0) && !ev_stall;
    assign pop      = count != '0;

    tpf_byte_fifo #(
        .DEPTH (FIFO_DEPTH),
        .MAXW  (REC_MAX)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_len  (rec.len),
        .wr_data (rec.data),
        .pop     (pop),
        .rd_data (td_byte),
        .count   (count)
    );

    assign td_valid = pop;

    // R10: a stall can only happen while bytes are still waiting to drain
    a_r10_stall_needs_backlog: assert property (@(posedge clk) disable iff (rst)
        ev_stall |-> td_valid);

    // R6: with ownership off and no branch, nothing is offered, so no stall
    a_r6_own_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cfg_own_en && !br_valid) |-> !ev_stall);

    // R9: an idle port with nothing offered stays idle on the next cycle
    a_r9_idle_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!td_valid && !br_valid && !own_user_entry && !own_asid_load && !own_pc_sync)
        |=> !td_valid);

endmodule

// File: tb/trace_payload_fmt_bench.sv
module trace_payload_fmt_bench;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cfg_tgt_sel;
    logic        cfg_own_en;
    logic        br_valid;
    logic [31:0] br_target;
    logic        own_user_entry;
    logic        own_asid_load;
    logic        own_pc_sync;
    logic [7:0]  own_asid;
    logic        ev_stall;
    logic        td_valid;
    logic [7:0]  td_byte;

    int checks = 0;
    int errors = 0;
    logic [7:0] mq  [$];
    logic [7:0] got [$];
    int stall_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trace_payload_fmt #(.FIFO_DEPTH(DEPTH)) u_trace_payload_fmt (
        .clk            (clk),
        .rst            (rst),
        .cfg_tgt_sel    (cfg_tgt_sel),
        .cfg_own_en     (cfg_own_en),
        .br_valid       (br_valid),
        .br_target      (br_target),
        .own_user_entry (own_user_entry),
        .own_asid_load  (own_asid_load),
        .own_pc_sync    (own_pc_sync),
        .own_asid       (own_asid),
        .ev_stall       (ev_stall),
        .td_valid       (td_valid),
        .td_byte        (td_byte)
    );

    function automatic void expect_rec(ref logic [7:0] q[$]);
        int n;
        q.delete();
        n = !br_valid ? 0 : (cfg_tgt_sel == 2'b00 ? 0 : int'(cfg_tgt_sel) + 1);
        for (int i = 0; i < n; i++) q.push_back(br_target[8*i +: 8]);
        if (cfg_own_en && (own_user_entry || own_asid_load || own_pc_sync))
            q.push_back(own_asid);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        br_valid = 0; own_user_entry = 0; own_asid_load = 0; own_pc_sync = 0;
    endtask

    // One cycle: inputs already driven at the negedge; check, update model, advance.
    task automatic cycle(output bit accepted);
        logic [7:0] r[$];
        bit exp_stall;
        #1;
        check(td_valid == (mq.size() != 0), "R9", "td_valid", td_valid, mq.size() != 0);
        if (mq.size() != 0)
            check(td_byte == mq[0], "R9", "td_byte", td_byte, mq[0]);
        expect_rec(r);
        exp_stall = r.size() > (DEPTH - mq.size());
        check(ev_stall == exp_stall, "R10", "ev_stall", ev_stall, exp_stall);
        if (ev_stall) stall_seen++;
        if (mq.size() != 0) begin
            got.push_back(td_byte);
            void'(mq.pop_front());
        end
        accepted = (r.size() != 0) && !exp_stall;
        if (accepted) foreach (r[i]) mq.push_back(r[i]);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        bit a;
        idle_inputs();
        while (mq.size() != 0) cycle(a);
        cycle(a);
    endtask

    // Offer the event on the current inputs until accepted, then drain and compare.
    task automatic directed(input string req, input logic [7:0] exp[$]);
        bit a;
        got.delete();
        if (exp.size() != 0) begin
            a = 0;
            while (!a) cycle(a);
        end else begin
            cycle(a);
        end
        drain();
        check(got.size() == exp.size(), req, "record length", got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            check(got[i] == exp[i], req, "record byte", got[i], exp[i]);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] e[$];
        bit a;
        void'($urandom(32'h5eed_1234));
        rst = 1; cfg_tgt_sel = 2'b11; cfg_own_en = 1; br_target = 32'h0;
        own_asid = 8'h00; idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!td_valid && !ev_stall, "R1", "idle after reset", {td_valid, ev_stall}, 0);
        rst = 0;

        // R2..R5: each target size, LSB first
        br_target = 32'hA1B2C3D4; cfg_own_en = 0;
        for (int s = 0; s < 4; s++) begin
            cfg_tgt_sel = 2'(s); br_valid = 1;
            e.delete();
            for (int i = 0; i < (s == 0 ? 0 : s + 1); i++) e.push_back(br_target[8*i +: 8]);
            case (s)
                0: directed("R2", e);
                1: directed("R3", e);
                2: directed("R4", e);
                default: directed("R5", e);
            endcase
        end

        // R6: ownership off, all triggers raised, no branch
        cfg_own_en = 0; own_asid = 8'h5A;
        own_user_entry = 1; own_asid_load = 1; own_pc_sync = 1;
        e.delete();
        directed("R6", e);

        // R7: each trigger alone, then all together
        cfg_own_en = 1;
        own_user_entry = 1; own_asid = 8'h11; e = '{8'h11}; directed("R7", e);
        own_asid_load  = 1; own_asid = 8'h22; e = '{8'h22}; directed("R7", e);
        own_pc_sync    = 1; own_asid = 8'h33; e = '{8'h33}; directed("R7", e);
        own_user_entry = 1; own_asid_load = 1; own_pc_sync = 1; own_asid = 8'h44;
        e = '{8'h44}; directed("R7", e);

        // R8: branch plus ASID in one record
        cfg_tgt_sel = 2'b10; br_valid = 1; br_target = 32'h0BADF00D;
        own_asid_load = 1; own_asid = 8'h77;
        e = '{8'h0D, 8'hF0, 8'hAD, 8'h77};
        directed("R8", e);

        // R11: configuration change right after acceptance
        got.delete();
        cfg_tgt_sel = 2'b11; cfg_own_en = 1; br_valid = 1; br_target = 32'h12345678;
        own_pc_sync = 1; own_asid = 8'h9C;
        cycle(a);
        check(a, "R11", "accepted", a, 1);
        idle_inputs(); cfg_tgt_sel = 2'b00; cfg_own_en = 0;
        drain();
        e = '{8'h78, 8'h56, 8'h34, 8'h12, 8'h9C};
        check(got.size() == 5, "R11", "record length", got.size(), 5);
        for (int i = 0; i < 5 && i < got.size(); i++)
            check(got[i] == e[i], "R11", "record byte", got[i], e[i]);

        // R10: two maximal records back to back
        got.delete(); stall_seen = 0;
        cfg_tgt_sel = 2'b11; cfg_own_en = 1; br_valid = 1; own_user_entry = 1;
        br_target = 32'hCAFEBEEF; own_asid = 8'h01;
        cycle(a);
        br_target = 32'h87654321; own_asid = 8'h02;
        a = 0;
        while (!a) cycle(a);
        drain();
        check(stall_seen >= 2, "R10", "stall cycles", stall_seen, 2);
        e = '{8'hEF, 8'hBE, 8'hFE, 8'hCA, 8'h01, 8'h21, 8'h43, 8'h65, 8'h87, 8'h02};
        check(got.size() == 10, "R10", "bytes after stall", got.size(), 10);
        for (int i = 0; i < 10 && i < got.size(); i++)
            check(got[i] == e[i], "R10", "byte after stall", got[i], e[i]);

        // Random traffic, events held while stalled
        for (int n = 0; n < 400; n++) begin
            if (!ev_stall) begin
                cfg_tgt_sel    = 2'($urandom_range(0, 3));
                cfg_own_en     = 1'($urandom_range(0, 1));
                br_valid       = ($urandom_range(0, 9) < 6);
                br_target      = $urandom;
                own_user_entry = ($urandom_range(0, 9) < 2);
                own_asid_load  = ($urandom_range(0, 9) < 2);
                own_pc_sync    = ($urandom_range(0, 9) < 1);
                own_asid       = 8'($urandom);
            end
            cycle(a);
        end
        drain();

        // R1: reset while the FIFO holds bytes
        cfg_tgt_sel = 2'b11; cfg_own_en = 1; br_valid = 1; own_pc_sync = 1;
        cycle(a);
        idle_inputs();
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0; mq.delete();
        #1;
        check(!td_valid, "R1", "td_valid after reset", td_valid, 0);
        check(!ev_stall, "R1", "ev_stall after reset", ev_stall, 0);
        @(negedge clk);
        check(!td_valid, "R1", "still empty", td_valid, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule